// File: doc/BRIEF.md
# Paged Supply-Monitor Command Register File

This block is the command-level register file of a multi-channel supply monitor. A host selects a page and a one-byte command code. It then writes a value or reads one back. The page decides which storage a command reaches. Pages 0 to 11 are sequenced and margined supply channels. Pages 12 to 15 are general measurement channels. Pages 16 to 20 are temperature sensors. Page 255 means every page, and pages 21 to 254 are reserved. Bus framing, packet checksums, non-volatile storage and measurement all sit outside the block.

A write transaction opens with a one-cycle `txn_start` that carries the byte count. The bytes follow on `wr_valid`/`wr_byte`. The first byte is the command code and the rest are data, least significant byte first. A read is a one-cycle `rd_req`. It returns the value of the most recently latched command code on the current page, together with its byte count. Writes to read-only commands set communication-fault status bits on the current page. Commands the block does not know raise a one-cycle error.

Top module: `pmon_regfile`

## Requirements
- R1: After reset, every page 0–20 reads operation (0x01) 0x80, on/off config (0x02) 0x1A, output mode (0x20) 0x40 and revision (0x98) 0x11. Capability (0x19) reads 0x20. On pages 0–15, scale (0x2A), minimum (0xD7) and over-voltage fault limit (0x40) read 0x7FFF, and channel config (0xE4) reads 0x0020. Turn-on fault limit (0x62) reads 0xFFFF on pages 0–11, over-temperature limit (0x4F) reads 0x7FFF on pages 16–20, and location (0x9C) reads 0x3130313031303130.
- R2: A transaction of length zero is rejected. It raises `err` for one cycle, two cycles after `txn_start`, and changes nothing. A transaction of length one latches the command code and changes no register.
- R3: Data bytes are taken and returned least significant byte first. Read length is 1 for byte commands, 2 for words, 4 for 32-bit commands (supply-enable config 0xD2) and 8 for location (0x9C).
- R4: Turn-on delay (0x60), turn-on fault limit (0x62), turn-off delay (0x64), supply-enable config (0xD2), margin config (0xDF), PWM config (0xE7) and sequence config (0xE8) exist per page only on pages 0–11. On any other page, a write is ignored and a read returns length 0.
- R5: Power-good on/off (0x5E/0x5F), scale, over-voltage limit, peak (0xD4), minimum, average current (0xE2, reads 0) and channel config exist per page only on pages 0–15. Elsewhere they behave as in R4.
- R6: Temperature peak (0xD6), temperature sensor config (0xF0) and over-temperature limit are held per sensor, indexed by page minus 16, and are valid on pages 16–20 only. A temperature-peak read on any other page returns sensor entry 0.
- R7: A write carrying data to a read-only command (fault log 0xDC, firmware revision 0xE0, average current 0xE2) on a page 0–20 sets bit 1 of that page's status word (0x79) and bit 6 of its fault status (0x7E). It changes no other register. `cml_alert` is the OR of all status-word bit 1 values.
- R8: Firmware revision (0xE0) reads 0x0001 only when the page is 255. On any other page it returns length 0.
- R9: A write to operation or on/off config on page 255 updates all pages 0–20. A read of either on page 255 returns length 0.
- R10: An unknown command code raises `err` for exactly one cycle on a data write and on a read, and changes no register. The read returns 0xFF with length 1. Writes to capability, output mode, revision and the two status commands count as unknown.
- R11: `rd_valid` is high exactly in the cycle after each `rd_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Opens a write transaction |
| txn_len | input | 4 | Byte count of the transaction, command byte included |
| wr_valid | input | 1 | Write byte valid |
| wr_byte | input | 8 | Write byte: code first, then data LSB first |
| rd_req | input | 1 | Read of the latched command on the current page |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 64 | Read value, zero-extended |
| rd_len | output | 4 | Bytes in the read response, 0 when the command does not apply |
| err | output | 1 | One-cycle pulse for a rejected or unknown command |
| cml_alert | output | 1 | Some page has its communication-fault status bit set |

## Verification
A read response is registered once, so it is sampled at the falling edge after the rising edge that takes `rd_req`. A written value moves through the byte assembler and then the register stage. For that reason the bench waits three cycles after the last byte before it reads. An error pulse comes two cycles after a zero-length start and one cycle after a read. The bench counts the cycles in which `err` is high, so a pulse that lasts too long or never comes shows up as a count mismatch.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
    localparam logic [7:0] CMD_PAGE    = 8'h00;
    localparam logic [7:0] CMD_OPER    = 8'h01;
    localparam logic [7:0] CMD_ONOFF   = 8'h02;
    localparam logic [7:0] CMD_CAPAB   = 8'h19;
    localparam logic [7:0] CMD_VMODE   = 8'h20;
    localparam logic [7:0] CMD_VSCALE  = 8'h2A;
    localparam logic [7:0] CMD_OVLIM   = 8'h40;
    localparam logic [7:0] CMD_OTLIM   = 8'h4F;
    localparam logic [7:0] CMD_PGON    = 8'h5E;
    localparam logic [7:0] CMD_PGOFF   = 8'h5F;
    localparam logic [7:0] CMD_TONDLY  = 8'h60;
    localparam logic [7:0] CMD_TONMAX  = 8'h62;
    localparam logic [7:0] CMD_TOFFDLY = 8'h64;
    localparam logic [7:0] CMD_STWORD  = 8'h79;
    localparam logic [7:0] CMD_STCML   = 8'h7E;
    localparam logic [7:0] CMD_REV     = 8'h98;
    localparam logic [7:0] CMD_LOC     = 8'h9C;
    localparam logic [7:0] CMD_ENCFG   = 8'hD2;
    localparam logic [7:0] CMD_VPEAK   = 8'hD4;
    localparam logic [7:0] CMD_TPEAK   = 8'hD6;
    localparam logic [7:0] CMD_VMIN    = 8'hD7;
    localparam logic [7:0] CMD_FLOG    = 8'hDC;
    localparam logic [7:0] CMD_MARGIN  = 8'hDF;
    localparam logic [7:0] CMD_FWREV   = 8'hE0;
    localparam logic [7:0] CMD_IAVG    = 8'hE2;
    localparam logic [7:0] CMD_CHCFG   = 8'hE4;
    localparam logic [7:0] CMD_PWMCFG  = 8'hE7;
    localparam logic [7:0] CMD_SEQCFG  = 8'hE8;
    localparam logic [7:0] CMD_TSCFG   = 8'hF0;

    localparam logic [7:0]  PAGE_ALL      = 8'hFF;
    localparam logic [7:0]  RST_OPER      = 8'h80;
    localparam logic [7:0]  RST_ONOFF     = 8'h1A;
    localparam logic [7:0]  RST_VMODE     = 8'h40;
    localparam logic [7:0]  RST_REV       = 8'h11;
    localparam logic [7:0]  RST_CAPAB     = 8'h20;
    localparam logic [15:0] RST_LIMIT     = 16'h7FFF;
    localparam logic [15:0] RST_TONMAX    = 16'hFFFF;
    localparam logic [15:0] RST_CHCFG     = 16'h0020;
    localparam logic [63:0] RST_LOC       = 64'h3130313031303130;
    localparam int          STW_CML_BIT   = 1;
    localparam int          CML_DATA_BIT  = 6;
endpackage

// File: rtl/pmon_page_class.sv
module pmon_page_class #(
    parameter int NUM_SEQ  = 12,
    parameter int NUM_MON  = 16,
    parameter int NUM_TEMP = 5
) (
    input  logic [7:0] page,
    output logic       is_seq,
    output logic       is_mon,
    output logic       is_tmp,
    output logic       is_real,
    output logic       is_all
);
    import pmon_pkg::*;
    localparam int NUM_PG = NUM_MON + NUM_TEMP;

    always_comb begin
        is_seq  = (int'(page) < NUM_SEQ);
        is_mon  = (int'(page) < NUM_MON);
        is_tmp  = (int'(page) >= NUM_MON) && (int'(page) < NUM_PG);
        is_real = (int'(page) < NUM_PG);
        is_all  = (page == PAGE_ALL);
    end
endmodule

// File: rtl/pmon_wr_asm.sv
module pmon_wr_asm #(
    parameter int MAXB = 8,
    localparam int LW  = $clog2(MAXB + 2),
    localparam int DW  = 8 * MAXB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] len,
    input  logic          byte_valid,
    input  logic [7:0]    byte_in,
    output logic          commit,
    output logic          reject,
    output logic [7:0]    code,
    output logic [DW-1:0] data,
    output logic [LW-1:0] dlen
);
    typedef struct packed {
        logic          busy;
        logic [LW-1:0] rem;
        logic [LW-1:0] idx;
        logic [7:0]    code;
        logic [DW-1:0] data;
        logic          commit;
        logic          reject;
        logic [LW-1:0] dlen;
    } asm_t;

    asm_t q, d;
    int   bpos;

    always_comb begin
        d = q;
        d.commit = 1'b0;
        d.reject = 1'b0;
        bpos = 8 * (int'(q.idx) - 1);
        if (start) begin
            if (len == '0) begin
                d.reject = 1'b1;
                d.busy   = 1'b0;
            end else begin
                d.busy = 1'b1;
                d.rem  = len;
                d.idx  = '0;
                d.data = '0;
            end
        end else if (q.busy && byte_valid) begin
            if (q.idx == '0) begin
                d.code = byte_in;
            end else if (int'(q.idx) <= MAXB) begin
                d.data[bpos +: 8] = byte_in;
            end
            d.idx = q.idx + 1'b1;
            d.rem = q.rem - 1'b1;
            if (q.rem == LW'(1)) begin
                d.busy   = 1'b0;
                d.commit = 1'b1;
                d.dlen   = (int'(q.idx) > MAXB) ? LW'(MAXB) : q.idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign commit = q.commit;
    assign reject = q.reject;
    assign code   = q.code;
    assign data   = q.data;
    assign dlen   = q.dlen;
endmodule

// File: rtl/pmon_regfile.sv
module pmon_regfile #(
    parameter int NUM_SEQ  = 12,
    parameter int NUM_MON  = 16,
    parameter int NUM_TEMP = 5,
    parameter int MAXB     = 8,
    localparam int LW      = $clog2(MAXB + 2),
    localparam int DW      = 8 * MAXB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          txn_start,
    input  logic [LW-1:0] txn_len,
    input  logic          wr_valid,
    input  logic [7:0]    wr_byte,
    input  logic          rd_req,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic [3:0]    rd_len,
    output logic          err,
    output logic          cml_alert
);
    import pmon_pkg::*;

    localparam int NUM_PG = NUM_MON + NUM_TEMP;
    localparam int PW     = $clog2(NUM_PG);
    localparam int MW     = $clog2(NUM_MON);
    localparam int SW     = $clog2(NUM_SEQ);
    localparam int TW     = (NUM_TEMP > 1) ? $clog2(NUM_TEMP) : 1;

    typedef struct packed {
        logic [7:0]                      code;
        logic [7:0]                      page;
        logic [63:0]                     loc;
        logic [NUM_PG-1:0][7:0]          oper;
        logic [NUM_PG-1:0][7:0]          onoff;
        logic [NUM_PG-1:0][15:0]         stw;
        logic [NUM_PG-1:0][7:0]          stcml;
        logic [NUM_MON-1:0][15:0]        pgon;
        logic [NUM_MON-1:0][15:0]        pgoff;
        logic [NUM_MON-1:0][15:0]        vscale;
        logic [NUM_MON-1:0][15:0]        ovlim;
        logic [NUM_MON-1:0][15:0]        vpeak;
        logic [NUM_MON-1:0][15:0]        vmin;
        logic [NUM_MON-1:0][15:0]        chcfg;
        logic [NUM_SEQ-1:0][15:0]        tondly;
        logic [NUM_SEQ-1:0][15:0]        tonmax;
        logic [NUM_SEQ-1:0][15:0]        toffdly;
        logic [NUM_SEQ-1:0][15:0]        margin;
        logic [NUM_SEQ-1:0][31:0]        encfg;
        logic [NUM_SEQ-1:0][31:0]        pwmcfg;
        logic [NUM_SEQ-1:0][31:0]        seqcfg;
        logic [NUM_TEMP-1:0][15:0]       tpeak;
        logic [NUM_TEMP-1:0][15:0]       tscfg;
        logic [NUM_TEMP-1:0][15:0]       otlim;
        logic                            rd_valid;
        logic [DW-1:0]                   rd_data;
        logic [3:0]                      rd_len;
        logic                            err;
    } regs_t;

    function automatic regs_t reset_val();
        regs_t r;
        r = '0;
        r.loc = RST_LOC;
        for (int i = 0; i < NUM_PG; i++) begin
            r.oper[i]  = RST_OPER;
            r.onoff[i] = RST_ONOFF;
        end
        for (int i = 0; i < NUM_MON; i++) begin
            r.vscale[i] = RST_LIMIT;
            r.ovlim[i]  = RST_LIMIT;
            r.vmin[i]   = RST_LIMIT;
            r.chcfg[i]  = RST_CHCFG;
        end
        for (int i = 0; i < NUM_SEQ; i++) r.tonmax[i] = RST_TONMAX;
        for (int i = 0; i < NUM_TEMP; i++) r.otlim[i] = RST_LIMIT;
        return r;
    endfunction

    regs_t q, d;

    logic          a_commit, a_reject;
    logic [7:0]    a_code;
    logic [DW-1:0] a_data;
    logic [LW-1:0] a_dlen;
    logic          pg_seq, pg_mon, pg_tmp, pg_real, pg_all;
    logic [7:0]    cur_code, cur_page;

    pmon_wr_asm #(.MAXB(MAXB)) u_asm (
        .clk(clk), .rst_n(rst_n), .start(txn_start), .len(txn_len),
        .byte_valid(wr_valid), .byte_in(wr_byte),
        .commit(a_commit), .reject(a_reject), .code(a_code),
        .data(a_data), .dlen(a_dlen)
    );

    pmon_page_class #(.NUM_SEQ(NUM_SEQ), .NUM_MON(NUM_MON), .NUM_TEMP(NUM_TEMP)) u_pcls (
        .page(q.page), .is_seq(pg_seq), .is_mon(pg_mon), .is_tmp(pg_tmp),
        .is_real(pg_real), .is_all(pg_all)
    );

    logic [PW-1:0] pidx;
    logic [MW-1:0] midx;
    logic [SW-1:0] sidx;
    logic [TW-1:0] tidx;
    logic [15:0]   w16;
    logic [31:0]   w32;

    assign pidx     = q.page[PW-1:0];
    assign midx     = q.page[MW-1:0];
    assign sidx     = q.page[SW-1:0];
    assign tidx     = TW'(q.page - 8'(NUM_MON));
    assign w16      = a_data[15:0];
    assign w32      = a_data[31:0];
    assign cur_code = q.code;
    assign cur_page = q.page;

    // write path: applied the cycle after the assembler commits
    always_comb begin
        d = q;
        d.rd_valid = 1'b0;
        d.err      = a_reject;
        if (a_commit) begin
            d.code = a_code;
            if (a_dlen != '0) begin
                case (a_code)
                    CMD_PAGE:    d.page = a_data[7:0];
                    CMD_LOC:     d.loc  = a_data[63:0];
                    CMD_OPER: begin
                        if (pg_all) for (int i = 0; i < NUM_PG; i++) d.oper[i] = a_data[7:0];
                        else if (pg_real) d.oper[pidx] = a_data[7:0];
                    end
                    CMD_ONOFF: begin
                        if (pg_all) for (int i = 0; i < NUM_PG; i++) d.onoff[i] = a_data[7:0];
                        else if (pg_real) d.onoff[pidx] = a_data[7:0];
                    end
                    CMD_PGON:    if (pg_mon) d.pgon[midx]   = w16;
                    CMD_PGOFF:   if (pg_mon) d.pgoff[midx]  = w16;
                    CMD_VSCALE:  if (pg_mon) d.vscale[midx] = w16;
                    CMD_OVLIM:   if (pg_mon) d.ovlim[midx]  = w16;
                    CMD_VPEAK:   if (pg_mon) d.vpeak[midx]  = w16;
                    CMD_VMIN:    if (pg_mon) d.vmin[midx]   = w16;
                    CMD_CHCFG:   if (pg_mon) d.chcfg[midx]  = w16;
                    CMD_TONDLY:  if (pg_seq) d.tondly[sidx]  = w16;
                    CMD_TONMAX:  if (pg_seq) d.tonmax[sidx]  = w16;
                    CMD_TOFFDLY: if (pg_seq) d.toffdly[sidx] = w16;
                    CMD_MARGIN:  if (pg_seq) d.margin[sidx]  = w16;
                    CMD_ENCFG:   if (pg_seq) d.encfg[sidx]   = w32;
                    CMD_PWMCFG:  if (pg_seq) d.pwmcfg[sidx]  = w32;
                    CMD_SEQCFG:  if (pg_seq) d.seqcfg[sidx]  = w32;
                    CMD_TPEAK:   if (pg_tmp) d.tpeak[tidx] = w16;
                    CMD_TSCFG:   if (pg_tmp) d.tscfg[tidx] = w16;
                    CMD_OTLIM:   if (pg_tmp) d.otlim[tidx] = w16;
                    CMD_FLOG, CMD_FWREV, CMD_IAVG: begin
                        if (pg_real) begin
                            d.stw[pidx][STW_CML_BIT]    = 1'b1;
                            d.stcml[pidx][CML_DATA_BIT] = 1'b1;
                        end
                    end
                    default:     d.err = 1'b1;
                endcase
            end
        end

        // read path: response registered one cycle after the request
        if (rd_req) begin
            d.rd_valid = 1'b1;
            d.rd_data  = '0;
            d.rd_len   = 4'd0;
            case (q.code)
                CMD_PAGE:    begin d.rd_data = DW'(q.page);  d.rd_len = 4'd1; end
                CMD_CAPAB:   begin d.rd_data = DW'(RST_CAPAB); d.rd_len = 4'd1; end
                CMD_LOC:     begin d.rd_data = DW'(q.loc);   d.rd_len = 4'd8; end
                CMD_OPER:    if (pg_real) begin d.rd_data = DW'(q.oper[pidx]);  d.rd_len = 4'd1; end
                CMD_ONOFF:   if (pg_real) begin d.rd_data = DW'(q.onoff[pidx]); d.rd_len = 4'd1; end
                CMD_VMODE:   if (pg_real) begin d.rd_data = DW'(RST_VMODE);     d.rd_len = 4'd1; end
                CMD_REV:     if (pg_real) begin d.rd_data = DW'(RST_REV);       d.rd_len = 4'd1; end
                CMD_STWORD:  if (pg_real) begin d.rd_data = DW'(q.stw[pidx]);   d.rd_len = 4'd2; end
                CMD_STCML:   if (pg_real) begin d.rd_data = DW'(q.stcml[pidx]); d.rd_len = 4'd1; end
                CMD_PGON:    if (pg_mon) begin d.rd_data = DW'(q.pgon[midx]);   d.rd_len = 4'd2; end
                CMD_PGOFF:   if (pg_mon) begin d.rd_data = DW'(q.pgoff[midx]);  d.rd_len = 4'd2; end
                CMD_VSCALE:  if (pg_mon) begin d.rd_data = DW'(q.vscale[midx]); d.rd_len = 4'd2; end
                CMD_OVLIM:   if (pg_mon) begin d.rd_data = DW'(q.ovlim[midx]);  d.rd_len = 4'd2; end
                CMD_VPEAK:   if (pg_mon) begin d.rd_data = DW'(q.vpeak[midx]);  d.rd_len = 4'd2; end
                CMD_VMIN:    if (pg_mon) begin d.rd_data = DW'(q.vmin[midx]);   d.rd_len = 4'd2; end
                CMD_CHCFG:   if (pg_mon) begin d.rd_data = DW'(q.chcfg[midx]);  d.rd_len = 4'd2; end
                CMD_IAVG:    if (pg_mon) d.rd_len = 4'd2;
                CMD_TONDLY:  if (pg_seq) begin d.rd_data = DW'(q.tondly[sidx]);  d.rd_len = 4'd2; end
                CMD_TONMAX:  if (pg_seq) begin d.rd_data = DW'(q.tonmax[sidx]);  d.rd_len = 4'd2; end
                CMD_TOFFDLY: if (pg_seq) begin d.rd_data = DW'(q.toffdly[sidx]); d.rd_len = 4'd2; end
                CMD_MARGIN:  if (pg_seq) begin d.rd_data = DW'(q.margin[sidx]);  d.rd_len = 4'd2; end
                CMD_ENCFG:   if (pg_seq) begin d.rd_data = DW'(q.encfg[sidx]);   d.rd_len = 4'd4; end
                CMD_PWMCFG:  if (pg_seq) begin d.rd_data = DW'(q.pwmcfg[sidx]);  d.rd_len = 4'd4; end
                CMD_SEQCFG:  if (pg_seq) begin d.rd_data = DW'(q.seqcfg[sidx]);  d.rd_len = 4'd4; end
                CMD_TPEAK: begin
                    d.rd_data = pg_tmp ? DW'(q.tpeak[tidx]) : DW'(q.tpeak[0]);
                    d.rd_len  = 4'd2;
                end
                CMD_TSCFG:   if (pg_tmp) begin d.rd_data = DW'(q.tscfg[tidx]); d.rd_len = 4'd2; end
                CMD_OTLIM:   if (pg_tmp) begin d.rd_data = DW'(q.otlim[tidx]); d.rd_len = 4'd2; end
                CMD_FLOG:    d.rd_len = 4'd4;
                CMD_FWREV:   if (pg_all) begin d.rd_data = DW'(16'h0001); d.rd_len = 4'd2; end
                default: begin
                    d.rd_data = DW'(8'hFF);
                    d.rd_len  = 4'd1;
                    d.err     = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= reset_val();
        else        q <= d;
    end

    always_comb begin
        cml_alert = 1'b0;
        for (int i = 0; i < NUM_PG; i++) cml_alert = cml_alert | q.stw[i][STW_CML_BIT];
    end

    assign rd_valid = q.rd_valid;
    assign rd_data  = q.rd_data;
    assign rd_len   = q.rd_len;
    assign err      = q.err;
endmodule

// File: rtl/pmon_regfile_chk.sv
module pmon_regfile_chk #(
    parameter int NUM_SEQ = 12,
    parameter int LW      = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          txn_start,
    input logic [LW-1:0] txn_len,
    input logic          rd_req,
    input logic          rd_valid,
    input logic [3:0]    rd_len,
    input logic          err,
    input logic          cml_alert,
    input logic [7:0]    cur_code,
    input logic [7:0]    cur_page
);
    p_rd_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    p_rd_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);

    p_len0_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_start && txn_len == '0) |=> ##1 err);

    p_fw_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && cur_code == 8'hE0 && cur_page != 8'hFF) |=> (rd_len == 4'd0));

    p_seq_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && cur_code == 8'h60 && int'(cur_page) >= NUM_SEQ) |=> (rd_len == 4'd0));

    p_cml_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cml_alert |=> cml_alert);
endmodule

bind pmon_regfile pmon_regfile_chk #(.NUM_SEQ(NUM_SEQ), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_len(txn_len),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_len(rd_len), .err(err),
    .cml_alert(cml_alert), .cur_code(cur_code), .cur_page(cur_page)
);

// File: tb/tb_pmon_regfile.sv
module tb_pmon_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        txn_start = 1'b0;
    logic [3:0]  txn_len = '0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_byte = '0;
    logic        rd_req = 1'b0;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic [3:0]  rd_len;
    logic        err;
    logic        cml_alert;

    int n_chk = 0;
    int n_bad = 0;
    int err_cnt = 0;
    logic [63:0] rv;
    logic [3:0]  rl;

    always #10 clk = ~clk;

    pmon_regfile dut (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_len(txn_len),
        .wr_valid(wr_valid), .wr_byte(wr_byte), .rd_req(rd_req),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_len(rd_len),
        .err(err), .cml_alert(cml_alert)
    );

    always @(posedge clk) if (rst_n && err) err_cnt <= err_cnt + 1;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_txn(input int len, input logic [79:0] bytes);
        @(negedge clk);
        txn_start = 1'b1;
        txn_len   = 4'(len);
        @(negedge clk);
        txn_start = 1'b0;
        for (int i = 0; i < len; i++) begin
            wr_valid = 1'b1;
            wr_byte  = bytes[8*i +: 8];
            @(negedge clk);
        end
        wr_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic set_page(input logic [7:0] p);
        wr_txn(2, {p, 8'h00});
    endtask

    task automatic wreg(input logic [7:0] code, input logic [63:0] val, input int nb);
        wr_txn(nb + 1, {val, code});
    endtask

    // R11: response sampled one edge after the request, and gone one edge later
    task automatic rd_cmd(input logic [7:0] code);
        wr_txn(1, {72'h0, code});
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        chk("R11 valid", 64'(rd_valid), 64'd1);
        rv = rd_data;
        rl = rd_len;
        @(negedge clk);
        chk("R11 drop", 64'(rd_valid), 64'd0);
    endtask

    task automatic t_reset;
        chk("R1 err idle", 64'(err), 64'd0);
        chk("R1 cml idle", 64'(cml_alert), 64'd0);
        rd_cmd(8'h01); chk("R1 operation", rv, 64'h80);
        rd_cmd(8'h02); chk("R1 onoff", rv, 64'h1A);
        rd_cmd(8'h98); chk("R1 revision", rv, 64'h11);
        rd_cmd(8'h20); chk("R1 vmode", rv, 64'h40);
        rd_cmd(8'h19); chk("R1 capability", rv, 64'h20);
        rd_cmd(8'h2A); chk("R1 scale", rv, 64'h7FFF);
        rd_cmd(8'h40); chk("R1 ov limit", rv, 64'h7FFF);
        rd_cmd(8'h62); chk("R1 ton max", rv, 64'hFFFF);
        rd_cmd(8'hE4); chk("R1 chcfg", rv, 64'h20);
        rd_cmd(8'hD7); chk("R1 vmin", rv, 64'h7FFF);
        rd_cmd(8'h9C); chk("R1 location", rv, 64'h3130313031303130);
        set_page(8'd20);
        rd_cmd(8'h4F); chk("R1 ot limit p20", rv, 64'h7FFF);
        rd_cmd(8'h01); chk("R1 operation p20", rv, 64'h80);
        set_page(8'd0);
    endtask

    task automatic t_len;
        int e0;
        wreg(8'h62, 64'h1234, 2);
        e0 = err_cnt;
        wr_txn(0, 80'h0);
        chk("R2 len0 err once", 64'(err_cnt - e0), 64'd1);
        rd_cmd(8'h62); chk("R2 len0 no change", rv, 64'h1234);
        wr_txn(1, 80'h64);
        rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
        chk("R2 len1 code latched len", 64'(rd_len), 64'd2);
        chk("R2 len1 code latched val", rd_data, 64'h0);
        @(negedge clk);
        rd_cmd(8'h62); chk("R2 len1 no change", rv, 64'h1234);
    endtask

    task automatic t_lsb;
        set_page(8'd3);
        wr_txn(5, {8'h11, 8'h22, 8'h33, 8'h44, 8'hD2});
        rd_cmd(8'hD2);
        chk("R3 lsb first 32", rv, 64'h11223344);
        chk("R3 len 32", 64'(rl), 64'd4);
        wreg(8'h9C, 64'h0102030405060708, 8);
        rd_cmd(8'h9C);
        chk("R3 lsb first 64", rv, 64'h0102030405060708);
        chk("R3 len 64", 64'(rl), 64'd8);
        set_page(8'd0);
    endtask

    task automatic t_seq;
        int e0;
        e0 = err_cnt;
        set_page(8'd12);
        wreg(8'h60, 64'hBEEF, 2);
        rd_cmd(8'h60); chk("R4 page12 len", 64'(rl), 64'd0);
        chk("R4 no err", 64'(err_cnt - e0), 64'd0);
        set_page(8'd11);
        wreg(8'hE8, 64'hCAFE0001, 4);
        rd_cmd(8'hE8); chk("R4 page11 seqcfg", rv, 64'hCAFE0001);
        set_page(8'd0);
        rd_cmd(8'h60); chk("R4 page0 untouched", rv, 64'h0);
    endtask

    task automatic t_mon;
        set_page(8'd15);
        wreg(8'hE4, 64'h0077, 2);
        rd_cmd(8'hE4); chk("R5 page15 chcfg", rv, 64'h77);
        set_page(8'd16);
        wreg(8'h5E, 64'h4444, 2);
        rd_cmd(8'h5E); chk("R5 page16 len", 64'(rl), 64'd0);
        set_page(8'd15);
        rd_cmd(8'h5E); chk("R5 page15 pgon untouched", rv, 64'h0);
        rd_cmd(8'hE2); chk("R5 iavg reads 0", rv, 64'h0);
    endtask

    task automatic t_temp;
        set_page(8'd18);
        wreg(8'hD6, 64'h0321, 2);
        rd_cmd(8'hD6); chk("R6 tpeak p18", rv, 64'h321);
        set_page(8'd16);
        wreg(8'hD6, 64'h0100, 2);
        set_page(8'd3);
        rd_cmd(8'hD6); chk("R6 tpeak fallback entry0", rv, 64'h100);
        set_page(8'd20);
        wreg(8'hF0, 64'h0055, 2);
        rd_cmd(8'hF0); chk("R6 tscfg p20", rv, 64'h55);
        set_page(8'd21);
        rd_cmd(8'hF0); chk("R6 tscfg p21 len", 64'(rl), 64'd0);
    endtask

    task automatic t_ro;
        chk("R7 cml clear before", 64'(cml_alert), 64'd0);
        set_page(8'd5);
        wreg(8'hE2, 64'h1111, 2);
        chk("R7 cml alert", 64'(cml_alert), 64'd1);
        rd_cmd(8'h79); chk("R7 status word", rv, 64'h0002);
        rd_cmd(8'h7E); chk("R7 fault status", rv, 64'h40);
        rd_cmd(8'hE2); chk("R7 iavg unchanged", rv, 64'h0);
        set_page(8'd4);
        rd_cmd(8'h79); chk("R7 other page clean", rv, 64'h0);
    endtask

    task automatic t_fw;
        set_page(8'hFF);
        rd_cmd(8'hE0); chk("R8 fw p255", rv, 64'h1);
        chk("R8 fw len", 64'(rl), 64'd2);
        set_page(8'd0);
        rd_cmd(8'hE0); chk("R8 fw p0 len", 64'(rl), 64'd0);
    endtask

    task automatic t_all;
        set_page(8'hFF);
        wreg(8'h01, 64'h00, 1);
        wreg(8'h02, 64'h05, 1);
        rd_cmd(8'h01); chk("R9 p255 read len", 64'(rl), 64'd0);
        set_page(8'd0);
        rd_cmd(8'h01); chk("R9 oper p0", rv, 64'h0);
        set_page(8'd11);
        rd_cmd(8'h02); chk("R9 onoff p11", rv, 64'h5);
        set_page(8'd20);
        rd_cmd(8'h01); chk("R9 oper p20", rv, 64'h0);
    endtask

    task automatic t_unsup;
        int e0;
        set_page(8'd0);
        e0 = err_cnt;
        rd_cmd(8'h77);
        chk("R10 read FF", rv, 64'hFF);
        chk("R10 read len", 64'(rl), 64'd1);
        chk("R10 read err once", 64'(err_cnt - e0), 64'd1);
        e0 = err_cnt;
        wreg(8'h19, 64'h99, 1);
        chk("R10 write err once", 64'(err_cnt - e0), 64'd1);
        rd_cmd(8'h19); chk("R10 capability kept", rv, 64'h20);
        wreg(8'h77, 64'h1, 1);
        rd_cmd(8'h2A); chk("R10 scale kept", rv, 64'h7FFF);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_len();
        t_lsb();
        t_seq();
        t_mon();
        t_temp();
        t_ro();
        t_fw();
        t_all();
        t_unsup();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule